// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between an 8-bit parallel host bus and the inside of a serial peripheral. A static mode input selects one of two bus families. In split-strobe mode, separate active-low read and write strobes qualify each access. In direction-line mode, a chip select qualifies the access and the write-strobe pin becomes a read/write direction line. The mode input also selects the polarity of the external reset pin and the polarity and drive style of the interrupt pad. Every host input passes through a two-flop synchroniser. Each qualified access then produces exactly one single-cycle internal read or write pulse, taken from its leading edge. The block also captures the address and the write data for the rest of the peripheral.

The block holds a small control register and a status register. The control register carries the interrupt drive-style bit and the modem-status interrupt enable. The status register reports a pending modem-status request and the live ring state. A low-power input gates the clock request off at once and isolates the host bus. When that input is released, the block issues a full internal reset. A rising transition of the active-low ring-indicator input raises a modem-status request when the enable bit is set. Reading the status register clears that request.

Top module: `host_bus_front`

## Requirements
- R1: With `bus_mode_i`=1, a window with `cs_n_i`=0, `rd_n_i`=0 and `wr_n_i`=1 produces exactly one `rd_pulse_o` cycle. A window with `cs_n_i`=0 and `wr_n_i`=0 produces exactly one `wr_pulse_o` cycle. The pulse is high in the third clock cycle after the strobe is applied.
- R2: With `bus_mode_i`=0, `rd_n_i` has no effect. While `cs_n_i`=0, `wr_n_i`=1 gives one read pulse and `wr_n_i`=0 gives one write pulse.
- R3: The reset pin is active high when `bus_mode_i`=1 and active low when `bus_mode_i`=0. The inactive level of the pin leaves register contents unchanged.
- R4: With `bus_mode_i`=0, `irq_o` is always 0 and `irq_oe_o` equals the pending interrupt request (open-drain, active low).
- R5: With `bus_mode_i`=1 and control bit 5 set, `irq_oe_o` is 1 and `irq_o` equals the request.
- R6: With `bus_mode_i`=1 and control bit 5 clear, `irq_oe_o` equals the request and `irq_o` is 1 whenever the request is pending. The request is `core_irq_i` OR the modem-status request, and the pad follows it one cycle later.
- R7: While `lowpwr_i`=1, `clk_off_o` is 1 and `data_oe_o` is 0 in the same cycle, and strobes produce no pulses.
- R8: A falling `lowpwr_i` produces exactly one `int_rst_o` cycle. After that cycle the control register reads 0.
- R9: When control bit 3 is set, a 0-to-1 transition on `ri_n_i` sets status bit 0. When bit 3 is clear, the transition leaves status bit 0 at 0. Status bit 1 reads 1 while `ri_n_i` is low.
- R10: A status read returns the pending bit and then clears it, so the next status read returns bit 0 = 0.
- R11: `data_oe_o` is 1 only during a qualified read, and is 0 by the fifth cycle after the strobe is released. `data_o` bit 0 is the least significant bit of the register read.
- R12: A write to address 4 loads the control register with the bus value. The control register sits at address 4 and the status register at address 6. Reads of any other address return `core_rdata_i`. `host_addr_o` and `host_wdata_o` hold the captured address and data of the latest access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bus_mode_i | input | 1 | Bus family: 1 split strobes, 0 direction line |
| rst_pin_i | input | 1 | External reset pin, polarity set by mode |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low (split mode only) |
| wr_n_i | input | 1 | Write strobe (split) or direction, 1 = read (direction mode) |
| addr_i | input | 3 | Register address |
| data_i | input | 8 | Data bus input from pad |
| data_o | output | 8 | Data bus output to pad |
| data_oe_o | output | 1 | Data bus output enable |
| lowpwr_i | input | 1 | Low-power request, active high |
| clk_off_o | output | 1 | Clock-gate-off request |
| ri_n_i | input | 1 | Ring indicator, active low |
| core_irq_i | input | 1 | Interrupt request from the rest of the peripheral |
| core_rdata_i | input | 8 | Read data for addresses outside this block |
| host_addr_o | output | 3 | Address captured at the latest access |
| host_wdata_o | output | 8 | Write data captured at the latest access |
| rd_pulse_o | output | 1 | Single-cycle internal read pulse |
| wr_pulse_o | output | 1 | Single-cycle internal write pulse |
| int_rst_o | output | 1 | Internal synchronous reset, active high |
| irq_o | output | 1 | Interrupt pad value |
| irq_oe_o | output | 1 | Interrupt pad output enable |

## Verification
A strobe applied between edges reaches the first synchroniser flop at the next edge and the second one at the edge after. The read or write pulse, the captured address and data, the returned read data and the output enable are registered at the third edge. The bench therefore samples a whole strobe window at every falling edge and checks that the single pulse lands in sample three. A status-read clear takes effect one edge after the pulse, and a ring edge reaches the status bit three edges after the pin moves. Both are checked only after a settling wait of five cycles. The interrupt pad is checked one edge after `core_irq_i` changes. The low-power isolation and the clock-off request are checked one time step after the pin moves, with no clock edge in between.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  typedef enum logic {
    MODE_DIR   = 1'b0,
    MODE_SPLIT = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } access_t;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) stg <= d;
  end else begin : g_many
    always_ff @(posedge clk) stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbf_reset_ctl.sv
module hbf_reset_ctl (
  input  logic clk,
  input  logic bus_mode,
  input  logic rst_pin_s,
  input  logic lp_s,
  output logic rst_q
);
  import hbf_pkg::*;
  logic lp_prev;
  logic pin_active;
  logic lp_exit;

  assign pin_active = (bus_mode_e'(bus_mode) == MODE_SPLIT) ? rst_pin_s : ~rst_pin_s;
  assign lp_exit    = lp_prev & ~lp_s;

  always_ff @(posedge clk) begin
    lp_prev <= lp_s;
    rst_q   <= pin_active | lp_exit;
  end
endmodule

// File: rtl/hbf_access.sv
module hbf_access #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_mode,
  input  logic              cs_n_s,
  input  logic              rd_n_s,
  input  logic              wr_n_s,
  input  logic              lp_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              rd_rise,
  output logic              wr_rise,
  output logic              rd_pulse_q,
  output logic              wr_pulse_q,
  output logic              oe_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  import hbf_pkg::*;
  access_t lvl, lvl_q;
  logic    open_ok;

  assign open_ok = ~cs_n_s & ~lp_s & ~rst;

  always_comb begin
    lvl.wr = open_ok & ~wr_n_s;
    if (bus_mode_e'(bus_mode) == MODE_SPLIT) lvl.rd = open_ok & wr_n_s & ~rd_n_s;
    else                                     lvl.rd = open_ok & wr_n_s;
  end

  assign rd_rise = lvl.rd & ~lvl_q.rd;
  assign wr_rise = lvl.wr & ~lvl_q.wr;

  always_ff @(posedge clk) begin
    lvl_q <= lvl;
    if (rst) begin
      rd_pulse_q <= 1'b0;
      wr_pulse_q <= 1'b0;
      oe_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      rd_pulse_q <= rd_rise;
      wr_pulse_q <= wr_rise;
      oe_q       <= lvl.rd;
      if (rd_rise || wr_rise) addr_q <= addr_s;
      if (wr_rise) wdata_q <= data_s;
    end
  end
endmodule

// File: rtl/hbf_regs.sv
module hbf_regs #(
  parameter int              ADDR_W    = 3,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_A  = 3'd4,
  parameter logic [ADDR_W-1:0] STAT_A  = 3'd6,
  parameter int              MSIEN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_rise,
  input  logic              rd_rise,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              rd_pulse_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              ri_n_s,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              msi_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic              ri_prev;
  logic              ri_rise;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_mux;

  assign ri_rise = ri_n_s & ~ri_prev;

  always_comb begin
    status    = '0;
    status[0] = msi_q;
    status[1] = ~ri_n_s;
  end

  always_comb begin
    if (addr_s == CTRL_A)      rd_mux = ctrl_q;
    else if (addr_s == STAT_A) rd_mux = status;
    else                       rd_mux = core_rdata;
  end

  always_ff @(posedge clk) begin
    ri_prev <= ri_n_s;
    if (rst) begin
      ctrl_q  <= '0;
      msi_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_rise && addr_s == CTRL_A) ctrl_q <= data_s;
      if (ri_rise && ctrl_q[MSIEN_BIT])          msi_q <= 1'b1;
      else if (rd_pulse_q && addr_q == STAT_A)   msi_q <= 1'b0;
      if (rd_rise) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/hbf_irq_out.sv
module hbf_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic bus_mode,
  input  logic push_pull,
  input  logic req,
  output logic irq_q,
  output logic irq_oe_q
);
  import hbf_pkg::*;
  logic nxt_val;
  logic nxt_oe;

  always_comb begin
    if (bus_mode_e'(bus_mode) == MODE_DIR) begin
      nxt_val = 1'b0;
      nxt_oe  = req;
    end else begin
      nxt_val = req;
      nxt_oe  = push_pull | req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= 1'b0;
      irq_oe_q <= 1'b0;
    end else begin
      irq_q    <= nxt_val;
      irq_oe_q <= nxt_oe;
    end
  end
endmodule

// File: rtl/host_bus_front.sv
module host_bus_front #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_ADDR   = 4,
  parameter int STAT_ADDR   = 6,
  parameter int DRV_BIT     = 5,
  parameter int MSIEN_BIT   = 3
) (
  input  logic              clk,
  input  logic              bus_mode_i,
  input  logic              rst_pin_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              lowpwr_i,
  output logic              clk_off_o,
  input  logic              ri_n_i,
  input  logic              core_irq_i,
  input  logic [DATA_W-1:0] core_rdata_i,
  output logic [ADDR_W-1:0] host_addr_o,
  output logic [DATA_W-1:0] host_wdata_o,
  output logic              rd_pulse_o,
  output logic              wr_pulse_o,
  output logic              int_rst_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  localparam int                SYNC_W = 6 + ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [SYNC_W-1:0] raw_in, syn_in;
  logic              rst_pin_s, cs_n_s, rd_n_s, wr_n_s, lp_s, ri_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              rst_q;
  logic              rd_rise, wr_rise, oe_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              msi_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_req;

  assign raw_in = {rst_pin_i, cs_n_i, rd_n_i, wr_n_i, lowpwr_i, ri_n_i, addr_i, data_i};

  hbf_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign {rst_pin_s, cs_n_s, rd_n_s, wr_n_s, lp_s, ri_n_s, addr_s, data_s} = syn_in;

  hbf_reset_ctl u_rst (
    .clk       (clk),
    .bus_mode  (bus_mode_i),
    .rst_pin_s (rst_pin_s),
    .lp_s      (lp_s),
    .rst_q     (rst_q)
  );

  hbf_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk        (clk),
    .rst        (rst_q),
    .bus_mode   (bus_mode_i),
    .cs_n_s     (cs_n_s),
    .rd_n_s     (rd_n_s),
    .wr_n_s     (wr_n_s),
    .lp_s       (lp_s),
    .addr_s     (addr_s),
    .data_s     (data_s),
    .rd_rise    (rd_rise),
    .wr_rise    (wr_rise),
    .rd_pulse_q (rd_pulse_o),
    .wr_pulse_q (wr_pulse_o),
    .oe_q       (oe_q),
    .addr_q     (host_addr_o),
    .wdata_q    (host_wdata_o)
  );

  hbf_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_A(CTRL_A), .STAT_A(STAT_A), .MSIEN_BIT(MSIEN_BIT)
  ) u_regs (
    .clk        (clk),
    .rst        (rst_q),
    .wr_rise    (wr_rise),
    .rd_rise    (rd_rise),
    .addr_s     (addr_s),
    .data_s     (data_s),
    .rd_pulse_q (rd_pulse_o),
    .addr_q     (host_addr_o),
    .ri_n_s     (ri_n_s),
    .core_rdata (core_rdata_i),
    .ctrl_q     (ctrl_q),
    .msi_q      (msi_q),
    .rdata_q    (rdata_q)
  );

  assign irq_req = (core_irq_i | msi_q) & ~rst_q;

  hbf_irq_out u_irq (
    .clk       (clk),
    .rst       (rst_q),
    .bus_mode  (bus_mode_i),
    .push_pull (ctrl_q[DRV_BIT]),
    .req       (irq_req),
    .irq_q     (irq_o),
    .irq_oe_q  (irq_oe_o)
  );

  assign data_o    = rdata_q;
  assign data_oe_o = oe_q & ~lowpwr_i & ~rst_q;
  assign clk_off_o = lowpwr_i;
  assign int_rst_o = rst_q;
endmodule

// File: rtl/hbf_chk.sv
module hbf_chk #(
  parameter int DATA_W  = 8,
  parameter int DRV_BIT = 5
) (
  input logic              clk,
  input logic              bus_mode_i,
  input logic              lowpwr_i,
  input logic              data_oe_o,
  input logic              rd_pulse_o,
  input logic              wr_pulse_o,
  input logic              irq_o,
  input logic              irq_oe_o,
  input logic              int_rst_o,
  input logic [DATA_W-1:0] ctrl_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | (int_rst_o === 1'b1);

  p_rd_single_r1: assert property (@(posedge clk) disable iff (!armed)
    rd_pulse_o |=> !rd_pulse_o);
  p_wr_single_r1: assert property (@(posedge clk) disable iff (!armed)
    wr_pulse_o |=> !wr_pulse_o);
  p_no_dual_r2: assert property (@(posedge clk) disable iff (!armed)
    !(rd_pulse_o && wr_pulse_o));
  p_open_drain_r4: assert property (@(posedge clk) disable iff (!armed)
    (!bus_mode_i && irq_oe_o) |-> !irq_o);
  p_push_pull_r5: assert property (@(posedge clk) disable iff (!armed)
    (bus_mode_i && $past(bus_mode_i) && $past(ctrl_q[DRV_BIT]) && !$past(int_rst_o)) |-> irq_oe_o);
  p_lp_iso_r7: assert property (@(posedge clk) disable iff (!armed)
    lowpwr_i |-> !data_oe_o);
  p_lp_quiet_r7: assert property (@(posedge clk) disable iff (!armed)
    (lowpwr_i && $past(lowpwr_i) && $past(lowpwr_i, 2) && $past(lowpwr_i, 3)) |-> !(rd_pulse_o || wr_pulse_o));
  p_rst_clear_r8: assert property (@(posedge clk) disable iff (!armed)
    $past(int_rst_o) |-> (ctrl_q == '0));
  p_oe_not_rst_r11: assert property (@(posedge clk) disable iff (!armed)
    data_oe_o |-> !int_rst_o);
endmodule

bind host_bus_front hbf_chk #(.DATA_W(DATA_W), .DRV_BIT(DRV_BIT)) u_chk (
  .clk        (clk),
  .bus_mode_i (bus_mode_i),
  .lowpwr_i   (lowpwr_i),
  .data_oe_o  (data_oe_o),
  .rd_pulse_o (rd_pulse_o),
  .wr_pulse_o (wr_pulse_o),
  .irq_o      (irq_o),
  .irq_oe_o   (irq_oe_o),
  .int_rst_o  (int_rst_o),
  .ctrl_q     (ctrl_q)
);

// File: tb/tb_host_bus_front.sv
module tb_host_bus_front;
  logic       clk = 1'b0;
  logic       bus_mode_i = 1'b1, rst_pin_i = 1'b1, cs_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] data_i = '0, core_rdata_i = 8'h3C;
  logic       lowpwr_i = 1'b0, ri_n_i = 1'b1, core_irq_i = 1'b0;
  logic [7:0] data_o, host_wdata_o;
  logic [2:0] host_addr_o;
  logic       data_oe_o, clk_off_o, rd_pulse_o, wr_pulse_o, int_rst_o, irq_o, irq_oe_o;

  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  host_bus_front dut (
    .clk(clk), .bus_mode_i(bus_mode_i), .rst_pin_i(rst_pin_i), .cs_n_i(cs_n_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .lowpwr_i(lowpwr_i), .clk_off_o(clk_off_o),
    .ri_n_i(ri_n_i), .core_irq_i(core_irq_i), .core_rdata_i(core_rdata_i),
    .host_addr_o(host_addr_o), .host_wdata_o(host_wdata_o), .rd_pulse_o(rd_pulse_o),
    .wr_pulse_o(wr_pulse_o), .int_rst_o(int_rst_o), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_pin_i = bus_mode_i;
    cyc(4);
    rst_pin_i = ~bus_mode_i;
    cyc(5);
  endtask

  // One bus access; samples every cycle of the strobe window and the tail.
  task automatic access(input bit is_rd, input logic [2:0] a, input logic [7:0] wd,
                        output logic [7:0] rdat, output int nrd, output int nwr,
                        output int first, output bit oe_at, output bit oe_end);
    nrd = 0; nwr = 0; first = 0; rdat = '0; oe_at = 1'b0;
    addr_i = a; data_i = wd; cs_n_i = 1'b0;
    if (bus_mode_i) begin
      rd_n_i = ~is_rd; wr_n_i = is_rd;
    end else begin
      rd_n_i = 1'b0;      // ignored in direction mode
      wr_n_i = is_rd;
    end
    for (int i = 1; i <= 6; i++) begin
      cyc(1);
      if (rd_pulse_o || wr_pulse_o) begin
        if (first == 0) begin
          first = i; rdat = data_o; oe_at = data_oe_o;
        end
      end
      nrd += int'(rd_pulse_o);
      nwr += int'(wr_pulse_o);
    end
    cs_n_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      cyc(1);
      nrd += int'(rd_pulse_o);
      nwr += int'(wr_pulse_o);
    end
    oe_end = data_oe_o;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    logic [7:0] d; int r, w, f; bit o1, o2;
    access(1'b0, a, v, d, r, w, f, o1, o2);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    int r, w, f; bit o1, o2;
    access(1'b1, a, 8'h00, v, r, w, f, o1, o2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int nr, nw, fi, pulses;
    bit oa, oe;

    cyc(2);
    do_reset();
    // reset state (R3, R11)
    check("R11 oe after reset", int'(data_oe_o), 0);
    check("R6 irq_oe after reset", int'(irq_oe_o), 0);
    check("R3 int_rst idle", int'(int_rst_o), 0);
    rd_reg(3'd4, d);
    check("R3 ctrl after reset", int'(d), 0);

    // R1: split-strobe read with exact pulse timing
    access(1'b1, 3'd1, 8'h00, d, nr, nw, fi, oa, oe);
    check("R1 read pulses", nr, 1);
    check("R1 no write pulse on read", nw, 0);
    check("R1 pulse cycle", fi, 3);
    check("R11 oe during read", int'(oa), 1);
    check("R11 oe released", int'(oe), 0);
    check("R12 core read data", int'(d), 8'h3C);
    // R1/R12: write to non-register address
    access(1'b0, 3'd2, 8'h96, d, nr, nw, fi, oa, oe);
    check("R1 write pulses", nw, 1);
    check("R1 no read pulse on write", nr, 0);
    check("R1 write pulse cycle", fi, 3);
    check("R12 host_addr", int'(host_addr_o), 2);
    check("R12 host_wdata", int'(host_wdata_o), 8'h96);
    check("R11 no oe on write", int'(oa), 0);

    // R12/R11: exhaustive control write and read-back, split mode
    for (int v = 0; v < 256; v++) begin
      wr_reg(3'd4, 8'(v));
      rd_reg(3'd4, d);
      check("R12 ctrl readback", int'(d), v);
      check("R11 lsb", int'(d[0]), v % 2);
    end

    // R2: direction mode, rd_n held low is ignored
    bus_mode_i = 1'b0;
    do_reset();
    for (int v = 0; v < 16; v++) begin
      access(1'b0, 3'd4, 8'(v * 17), d, nr, nw, fi, oa, oe);
      check("R2 write pulses", nw, 1);
      check("R2 rd_n ignored", nr, 0);
      access(1'b1, 3'd4, 8'h00, d, nr, nw, fi, oa, oe);
      check("R2 read pulses", nr, 1);
      check("R2 readback", int'(d), v * 17);
    end
    // R3: inactive (high) pin in direction mode keeps contents
    rst_pin_i = 1'b1; cyc(5);
    rd_reg(3'd4, d);
    check("R3 high pin no reset in dir mode", int'(d), 8'hFF);
    rst_pin_i = 1'b0; cyc(4); rst_pin_i = 1'b1; cyc(5);
    rd_reg(3'd4, d);
    check("R3 low pin resets in dir mode", int'(d), 0);

    // R4/R5/R6: interrupt pad sweep
    for (int m = 0; m < 2; m++) begin
      for (int drv = 0; drv < 2; drv++) begin
        bus_mode_i = m[0];
        do_reset();
        wr_reg(3'd4, drv[0] ? 8'h20 : 8'h00);
        for (int q = 0; q < 2; q++) begin
          core_irq_i = q[0];
          cyc(1);
          if (m == 0) begin
            check("R4 irq value", int'(irq_o), 0);
            check("R4 irq enable", int'(irq_oe_o), q);
          end else if (drv == 1) begin
            check("R5 irq value", int'(irq_o), q);
            check("R5 irq enable", int'(irq_oe_o), 1);
          end else begin
            check("R6 irq value", int'(irq_o), q);
            check("R6 irq enable", int'(irq_oe_o), q);
          end
        end
        core_irq_i = 1'b0;
        cyc(1);
      end
    end

    // R9/R10: ring indicator
    bus_mode_i = 1'b1;
    do_reset();
    wr_reg(3'd4, 8'h00);
    ri_n_i = 1'b0; cyc(5);
    rd_reg(3'd6, d);
    check("R9 ring level bit", int'(d[1]), 1);
    ri_n_i = 1'b1; cyc(5);
    rd_reg(3'd6, d);
    check("R9 disabled edge ignored", int'(d[0]), 0);
    wr_reg(3'd4, 8'h28);
    ri_n_i = 1'b0; cyc(5);
    ri_n_i = 1'b1; cyc(5);
    check("R6 msi drives irq", int'(irq_o), 1);
    rd_reg(3'd6, d);
    check("R10 status pending", int'(d[0]), 1);
    check("R9 ring level released", int'(d[1]), 0);
    rd_reg(3'd6, d);
    check("R10 status cleared", int'(d[0]), 0);

    // R7/R8: low power
    wr_reg(3'd4, 8'hA5);
    addr_i = 3'd4; cs_n_i = 1'b0; rd_n_i = 1'b0; wr_n_i = 1'b1;
    cyc(4);
    check("R11 oe mid read", int'(data_oe_o), 1);
    lowpwr_i = 1'b1; #1;
    check("R7 clk_off immediate", int'(clk_off_o), 1);
    check("R7 bus isolated immediate", int'(data_oe_o), 0);
    cs_n_i = 1'b1; rd_n_i = 1'b1;
    cyc(4);
    access(1'b1, 3'd4, 8'h00, d, nr, nw, fi, oa, oe);
    check("R7 read ignored", nr, 0);
    access(1'b0, 3'd4, 8'h11, d, nr, nw, fi, oa, oe);
    check("R7 write ignored", nw, 0);
    check("R7 bus isolated", int'(data_oe_o), 0);
    pulses = 0;
    lowpwr_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      pulses += int'(int_rst_o);
    end
    check("R8 one reset pulse", pulses, 1);
    check("R7 clk_off released", int'(clk_off_o), 0);
    rd_reg(3'd4, d);
    check("R8 ctrl cleared", int'(d), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule